// File: doc/BRIEF.md
# Serial Channel Command Decoder

This block sits beside one channel of a serial controller and turns a single write of a 4-bit command code into one-shot actions on the channel's control and status state. It can reset the receiver side or the transmitter side on its own. It can clear the sticky receive-error bits or the delta-break interrupt flag. It can start or stop a transmitted break, and it can drive the request-to-send line to either level. Codes with no command assigned are ignored.

Status bits are held here. The receive path, the transmit path and the line monitor set them through single-cycle event inputs. Each bit stays set until the command that owns it is written. Two more event inputs turn the receiver and the transmitter on. When the receiver is reset, the block emits a one-cycle pulse so that an external receive FIFO can clear its read and write pointers. The shift engines, the baud timing and the FIFO storage belong to other blocks.

All outputs are registered. A command sampled at a clock edge, with its write strobe high, is visible on the outputs just after that edge.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: Codes 4'b0000, 4'b0001 and 4'b1010 through 4'b1111 are no-ops. Writing one of them changes no output and raises no FIFO pointer pulse.
- R2: Code 4'b0010 clears rx_en_o, rx_ffull_o and rx_rdy_o. It also drives fifo_ptr_rst_o high for exactly the one cycle after the write.
- R3: Code 4'b0011 clears tx_en_o, tx_emp_o and tx_rdy_o.
- R4: Codes 4'b0010 and 4'b0011 leave the error bits, the delta-break flag, the break request, rts_no and the other direction's bits unchanged.
- R5: Code 4'b0100 clears all four error bits in err_o together. The bit order is [3] received break, [2] framing, [1] parity, [0] overrun.
- R6: Code 4'b0101 clears dbrk_o and nothing else.
- R7: Code 4'b0110 sets brk_req_o and code 4'b0111 clears it.
- R8: Code 4'b1000 drives rts_no low (asserted) and code 4'b1001 drives it high (negated).
- R9: A status bit set by its event input stays set, over any number of idle cycles and unrelated commands, until its clearing command is written.
- R10: When a set event and the clearing command for the same bit arrive in the same cycle, the bit ends up cleared.
- R11: After reset, rts_no is 1 and every other output is 0.
- R12: A command acts only in a cycle where cmd_wr_i is high. Its effect appears one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_code_i | input | 4 | Command code |
| rx_en_set_i | input | 1 | Enable receiver event |
| tx_en_set_i | input | 1 | Enable transmitter event |
| rx_ffull_set_i | input | 1 | Receive FIFO full event |
| rx_rdy_set_i | input | 1 | Receive data ready event |
| tx_emp_set_i | input | 1 | Transmitter empty event |
| tx_rdy_set_i | input | 1 | Transmitter ready event |
| err_set_i | input | 4 | Error events: [3] break, [2] framing, [1] parity, [0] overrun |
| brk_chg_i | input | 1 | Break-change detected event |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_ffull_o | output | 1 | Receive FIFO full status |
| rx_rdy_o | output | 1 | Receive ready status |
| tx_emp_o | output | 1 | Transmitter empty status |
| tx_rdy_o | output | 1 | Transmitter ready status |
| err_o | output | 4 | Sticky error status, same order as err_set_i |
| dbrk_o | output | 1 | Delta-break interrupt flag |
| brk_req_o | output | 1 | Request to transmit break |
| rts_no | output | 1 | Request to send, active low |
| fifo_ptr_rst_o | output | 1 | One-cycle receive FIFO pointer reset |

## Verification
Some properties are checked on every cycle. Each status bit holds its value, takes its set event, and is cleared when its command is written, with the clear winning over a set in the same cycle. Each command code produces its own register effect on the next cycle, and the pointer pulse appears only after a receiver reset. Writes of unused codes, and idle cycles, leave the outputs stable. Only the bench scenarios can show the full code map against a state with every bit set, the reset values, and the way a receiver or transmitter reset leaves unrelated state alone over a longer sequence.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  parameter int CMD_W = 4;
  parameter int ERR_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_RST_RX  = 4'h2,
    CMD_RST_TX  = 4'h3,
    CMD_RST_ERR = 4'h4,
    CMD_RST_DBK = 4'h5,
    CMD_BRK_ON  = 4'h6,
    CMD_BRK_OFF = 4'h7,
    CMD_RTS_ON  = 4'h8,
    CMD_RTS_OFF = 4'h9
  } cmd_code_e;

  typedef struct packed {
    logic rst_rx;
    logic rst_tx;
    logic rst_err;
    logic rst_dbk;
    logic brk_on;
    logic brk_off;
    logic rts_on;
    logic rts_off;
  } cmd_act_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic             wr_i,
  input  logic [CMD_W-1:0] code_i,
  output cmd_act_t         act_o
);
  always_comb begin
    act_o = '0;
    if (wr_i) begin
      case (code_i)
        CMD_RST_RX:  act_o.rst_rx  = 1'b1;
        CMD_RST_TX:  act_o.rst_tx  = 1'b1;
        CMD_RST_ERR: act_o.rst_err = 1'b1;
        CMD_RST_DBK: act_o.rst_dbk = 1'b1;
        CMD_BRK_ON:  act_o.brk_on  = 1'b1;
        CMD_BRK_OFF: act_o.brk_off = 1'b1;
        CMD_RTS_ON:  act_o.rts_on  = 1'b1;
        CMD_RTS_OFF: act_o.rts_off = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    AST_ONE_ACTION: assert ($onehot0(act_o)); // R1
    AST_NO_WR_NO_ACT: assert (wr_i || act_o == '0); // R12
  end
endmodule

// File: rtl/uart_cmd_stat_reg.sv
module uart_cmd_stat_reg #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (clr_i[i]) q_o[i] <= 1'b0;  // clear wins over set
      else if (set_i[i]) q_o[i] <= 1'b1;
    end

    AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o[i] && !clr_i[i] |=> q_o[i]); // R9
    AST_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] && !clr_i[i] |=> q_o[i]); // R9
    AST_BIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] |=> !q_o[i]); // R10
    AST_BIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !q_o[i] && !set_i[i] |=> !q_o[i]); // R12
  end
endmodule

// File: rtl/uart_cmd_line.sv
module uart_cmd_line
  import uart_cmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmd_act_t act_i,
  output logic     brk_req_o,
  output logic     rts_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_req_o <= 1'b0;
      rts_no    <= 1'b1;
    end else begin
      if (act_i.brk_on)       brk_req_o <= 1'b1;
      else if (act_i.brk_off) brk_req_o <= 1'b0;
      if (act_i.rts_on)       rts_no <= 1'b0;
      else if (act_i.rts_off) rts_no <= 1'b1;
    end
  end

  AST_BRK_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.brk_on |=> brk_req_o); // R7
  AST_BRK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.brk_off |=> !brk_req_o); // R7
  AST_RTS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.rts_on |=> !rts_no); // R8
  AST_RTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.rts_off |=> rts_no); // R8
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             rx_en_set_i,
  input  logic             tx_en_set_i,
  input  logic             rx_ffull_set_i,
  input  logic             rx_rdy_set_i,
  input  logic             tx_emp_set_i,
  input  logic             tx_rdy_set_i,
  input  logic [ERR_W-1:0] err_set_i,
  input  logic             brk_chg_i,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             rx_ffull_o,
  output logic             rx_rdy_o,
  output logic             tx_emp_o,
  output logic             tx_rdy_o,
  output logic [ERR_W-1:0] err_o,
  output logic             dbrk_o,
  output logic             brk_req_o,
  output logic             rts_no,
  output logic             fifo_ptr_rst_o
);
  localparam int SIDE_W = 3;

  cmd_act_t act;

  uart_cmd_decode u_dec (.wr_i(cmd_wr_i), .code_i(cmd_code_i), .act_o(act));

  uart_cmd_stat_reg #(.W(SIDE_W)) u_rx (
    .clk_i, .rst_ni,
    .set_i({rx_en_set_i, rx_ffull_set_i, rx_rdy_set_i}),
    .clr_i({SIDE_W{act.rst_rx}}),
    .q_o  ({rx_en_o, rx_ffull_o, rx_rdy_o})
  );

  uart_cmd_stat_reg #(.W(SIDE_W)) u_tx (
    .clk_i, .rst_ni,
    .set_i({tx_en_set_i, tx_emp_set_i, tx_rdy_set_i}),
    .clr_i({SIDE_W{act.rst_tx}}),
    .q_o  ({tx_en_o, tx_emp_o, tx_rdy_o})
  );

  uart_cmd_stat_reg #(.W(ERR_W)) u_err (
    .clk_i, .rst_ni,
    .set_i(err_set_i),
    .clr_i({ERR_W{act.rst_err}}),
    .q_o  (err_o)
  );

  uart_cmd_stat_reg #(.W(1)) u_dbk (
    .clk_i, .rst_ni,
    .set_i(brk_chg_i),
    .clr_i(act.rst_dbk),
    .q_o  (dbrk_o)
  );

  uart_cmd_line u_line (.clk_i, .rst_ni, .act_i(act), .brk_req_o, .rts_no);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_ptr_rst_o <= 1'b0;
    else         fifo_ptr_rst_o <= act.rst_rx;
  end

  // checks against the port-level command code
  logic code_rx, code_tx, code_nop, no_evt;
  assign code_rx  = cmd_wr_i && cmd_code_i == 4'b0010;
  assign code_tx  = cmd_wr_i && cmd_code_i == 4'b0011;
  assign code_nop = cmd_wr_i && (cmd_code_i < 4'd2 || cmd_code_i > 4'd9);
  assign no_evt   = !(rx_en_set_i || tx_en_set_i || rx_ffull_set_i || rx_rdy_set_i ||
                      tx_emp_set_i || tx_rdy_set_i || brk_chg_i || |err_set_i);

  AST_RX_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_rx |=> fifo_ptr_rst_o && !rx_en_o && !rx_ffull_o && !rx_rdy_o); // R2
  AST_PTR_ONLY_ON_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_rx |=> !fifo_ptr_rst_o); // R2
  AST_TX_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_tx |=> !tx_en_o && !tx_emp_o && !tx_rdy_o); // R3
  AST_SIDE_RESET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_rx || code_tx) && no_evt |=>
      $stable(err_o) && $stable(dbrk_o) && $stable(brk_req_o) && $stable(rts_no)); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_code_i == 4'b0100 |=> err_o == '0); // R5
  AST_DBRK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_code_i == 4'b0101 && no_evt |=> !dbrk_o && $stable(err_o) &&
      $stable({rx_en_o, rx_ffull_o, rx_rdy_o, tx_en_o, tx_emp_o, tx_rdy_o})); // R6
  AST_NOP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_nop && no_evt |=> !fifo_ptr_rst_o && $stable(err_o) && $stable(dbrk_o) &&
      $stable(brk_req_o) && $stable(rts_no) &&
      $stable({rx_en_o, rx_ffull_o, rx_rdy_o, tx_en_o, tx_emp_o, tx_rdy_o})); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr_i && no_evt |=> $stable(err_o) && $stable(dbrk_o) && $stable(brk_req_o) &&
      $stable(rts_no) && $stable({rx_en_o, rx_ffull_o, rx_rdy_o, tx_en_o, tx_emp_o, tx_rdy_o})); // R12
endmodule

// File: tb/tb_uart_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_uart_cmd_ctrl;
  localparam real T = 4.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [3:0] cmd_code = '0;
  logic rx_en_s = 0, tx_en_s = 0, ffull_s = 0, rrdy_s = 0, temp_s = 0, trdy_s = 0, bchg = 0;
  logic [3:0] err_s = '0;
  logic rx_en, tx_en, ffull, rrdy, temp, trdy, dbrk, brk, rts_n, ptr;
  logic [3:0] err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(T/2) clk = ~clk;

  uart_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_code_i(cmd_code),
    .rx_en_set_i(rx_en_s), .tx_en_set_i(tx_en_s), .rx_ffull_set_i(ffull_s),
    .rx_rdy_set_i(rrdy_s), .tx_emp_set_i(temp_s), .tx_rdy_set_i(trdy_s),
    .err_set_i(err_s), .brk_chg_i(bchg),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_ffull_o(ffull), .rx_rdy_o(rrdy),
    .tx_emp_o(temp), .tx_rdy_o(trdy), .err_o(err), .dbrk_o(dbrk),
    .brk_req_o(brk), .rts_no(rts_n), .fifo_ptr_rst_o(ptr)
  );

  // order: rx_en ffull rrdy | tx_en temp trdy | err[3:0] | dbrk brk rts_n ptr
  function automatic logic [13:0] snap();
    return {rx_en, ffull, rrdy, tx_en, temp, trdy, err, dbrk, brk, rts_n, ptr};
  endfunction

  localparam logic [13:0] PRIMED = 14'b111_111_1111_1_1_0_0;

  typedef struct packed { logic [3:0] code; logic [13:0] exp; } vec_t;
  localparam vec_t VECS [16] = '{
    '{4'h0, PRIMED},                       // R1
    '{4'h1, PRIMED},                       // R1
    '{4'h2, 14'b000_111_1111_1_1_0_1},     // R2 R4
    '{4'h3, 14'b111_000_1111_1_1_0_0},     // R3 R4
    '{4'h4, 14'b111_111_0000_1_1_0_0},     // R5
    '{4'h5, 14'b111_111_1111_0_1_0_0},     // R6
    '{4'h6, PRIMED},                       // R7
    '{4'h7, 14'b111_111_1111_1_0_0_0},     // R7
    '{4'h8, PRIMED},                       // R8
    '{4'h9, 14'b111_111_1111_1_1_1_0},     // R8
    '{4'hA, PRIMED}, '{4'hB, PRIMED}, '{4'hC, PRIMED},
    '{4'hD, PRIMED}, '{4'hE, PRIMED}, '{4'hF, PRIMED}  // R1
  };

  task automatic chk(string tag, logic [13:0] got, logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic all_events(logic v);
    {rx_en_s, tx_en_s, ffull_s, rrdy_s, temp_s, trdy_s, bchg} = {7{v}};
    err_s = {4{v}};
  endtask

  task automatic cmd(logic [3:0] c);
    cmd_wr = 1'b1; cmd_code = c; step(); cmd_wr = 1'b0;
  endtask

  task automatic prime();
    all_events(1'b1); cmd_wr = 1'b1; cmd_code = 4'h6; step();
    all_events(1'b0); cmd_code = 4'h8; step();
    cmd_wr = 1'b0; step();
  endtask

  initial begin
    #(T * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 reset values", snap(), 14'b000_000_0000_0_0_1_0);
    rst_n = 1'b1; step();

    for (int i = 0; i < 16; i++) begin
      prime();
      chk("R9 primed state", snap(), PRIMED);
      cmd(VECS[i].code);
      chk($sformatf("R1-map code %h", VECS[i].code), snap(), VECS[i].exp);
    end

    // R2 pointer pulse lasts one cycle
    prime(); cmd(4'h2);
    chk("R2 pulse high", {13'b0, ptr}, 14'd1);
    step();
    chk("R2 pulse one cycle", {13'b0, ptr}, 14'd0);

    // R12 strobe low: no effect
    prime(); cmd_code = 4'h2; cmd_wr = 1'b0; step(); step();
    chk("R12 no strobe", snap(), PRIMED);

    // R9 sticky over idle cycles and unrelated commands
    repeat (5) step();
    cmd(4'h3); cmd(4'h5); cmd(4'h9);
    chk("R9 errors held", {10'b0, err}, 14'hF);

    // R10 clear beats set in the same cycle
    err_s = 4'hF; bchg = 1'b1; cmd(4'h4); err_s = '0; bchg = 1'b0;
    chk("R10 err clear wins", {10'b0, err}, 14'h0);
    chk("R9 dbrk set by event", {13'b0, dbrk}, 14'd1);
    rx_en_s = 1'b1; rrdy_s = 1'b1; cmd(4'h2); rx_en_s = 1'b0; rrdy_s = 1'b0;
    chk("R10 rx clear wins", {11'b0, rx_en, ffull, rrdy}, 14'd0);
    bchg = 1'b1; cmd(4'h5); bchg = 1'b0;
    chk("R10 dbrk clear wins", {13'b0, dbrk}, 14'd0);

    // R7 R8 from a reset state
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R11 after second reset", snap(), 14'b000_000_0000_0_0_1_0);
    cmd(4'h6);
    chk("R7 break start", snap(), 14'b000_000_0000_0_1_1_0);
    cmd(4'h8);
    chk("R8 rts asserted", snap(), 14'b000_000_0000_0_1_0_0);
    cmd(4'h7); cmd(4'h9);
    chk("R7 R8 back off", snap(), 14'b000_000_0000_0_0_1_0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule